// File: doc/BRIEF.md
# Offload Control Register Bank

This block is the software-facing register file of a sample offload engine. An AXI4-Lite slave (16-bit byte addresses, 32-bit data) gives a host access to identification words, build-time capability bits, per-path control fields, trigger-mode selectors, a trigger word and two debug words. Each of these fields is brought out as a plain level output to the receive-side and transmit-side offload controllers. The only exception is the trigger word, which is turned into single-cycle strobes. The controllers' current state codes and the transmit empty-read flag come back into the bank. They are sampled when a read of the matching debug word is accepted.

Every register lives on the bus clock, and there is one synchronous, active-high reset. A write needs both its address and its data beat, and the two may arrive in any order. The register update and the response are both issued one clock after the later of the two has been accepted. A read returns registered data one clock after its address is accepted. Addresses are decoded in full, so an unaligned address counts as unmapped.

Top module: `ofl_ctrl_regs`

## Requirements
- R1: After reset, all control outputs (path resets, bypass bits, one-shot, trigger strobes, forced states) are 0, both trigger modes are 0 (auto), and bvalid and rvalid are low.
- R2: Offset 0x00 reads {VER_MAJOR[15:0], VER_MINOR[7:0], VER_PATCH[7:0]}, 0x0C reads 0x44414F46, and 0x10 reads bit 0 = receive path present, bit 1 = transmit path present, bit 2 = external memory, with all other bits 0.
- R3: Offset 0x08 is a 32-bit scratch word. wstrb bit i updates only bits [8i+7:8i].
- R4: Write address and write data may be accepted in either order or in the same cycle. bvalid rises exactly one clock after the later acceptance and not before, bresp is 0 (OKAY), and bvalid stays high until bready.
- R5: rvalid rises one clock after the read address is accepted, with rresp 0. rdata and rvalid stay stable until rready. Unmapped or unaligned addresses read 0.
- R6: Offset 0x84 bit 0 drives rx_path_rst and bit 1 drives tx_path_rst. Both are levels that read back.
- R7: Offset 0x88 bit 0 drives rx_bypass. Offset 0x8C bit 0 drives tx_bypass and bit 1 drives tx_oneshot (0 = loop playback). Unused bits read 0.
- R8: Writing 1 to offset 0x100 bit 0 (bit 1) with wstrb[0] set gives exactly one cycle of rx_trig (tx_trig), coincident with bvalid rising. Writing 0 gives no strobe, and the word reads 0.
- R9: Offsets 0x104 and 0x108 hold 2-bit trigger-mode fields in bits [1:0] for receive and transmit (0 auto, 1 hardware, 2 software), driving rx_trig_mode and tx_trig_mode. The upper bits read 0.
- R10: Offset 0x200 (receive) and 0x204 (transmit) read the live state input in bits [7:0] and the forced state in bits [15:8]. The forced state is written through wstrb[1] and drives the force output. Writes to bits [7:0] are ignored. Bit 16 of 0x204 reflects tx_empty_read.
- R11: Writes to read-only or unmapped addresses change nothing but still complete with an OKAY response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| axil_awvalid | input | 1 | Write address valid |
| axil_awaddr | input | 16 | Write byte address |
| axil_awready | output | 1 | Write address ready |
| axil_wvalid | input | 1 | Write data valid |
| axil_wdata | input | 32 | Write data |
| axil_wstrb | input | 4 | Write byte strobes |
| axil_wready | output | 1 | Write data ready |
| axil_bvalid | output | 1 | Write response valid |
| axil_bresp | output | 2 | Write response code |
| axil_bready | input | 1 | Write response ready |
| axil_arvalid | input | 1 | Read address valid |
| axil_araddr | input | 16 | Read byte address |
| axil_arready | output | 1 | Read address ready |
| axil_rvalid | output | 1 | Read data valid |
| axil_rresp | output | 2 | Read response code |
| axil_rdata | output | 32 | Read data |
| axil_rready | input | 1 | Read data ready |
| rx_cur_state | input | 8 | Receive controller state code |
| tx_cur_state | input | 8 | Transmit controller state code |
| tx_empty_read | input | 1 | Transmit empty-read flag |
| rx_path_rst | output | 1 | Receive path reset level |
| tx_path_rst | output | 1 | Transmit path reset level |
| rx_bypass | output | 1 | Receive storage bypass |
| tx_bypass | output | 1 | Transmit storage bypass |
| tx_oneshot | output | 1 | Transmit one-shot playback |
| rx_trig | output | 1 | Receive trigger strobe |
| tx_trig | output | 1 | Transmit trigger strobe |
| rx_trig_mode | output | 2 | Receive trigger mode |
| tx_trig_mode | output | 2 | Transmit trigger mode |
| rx_force_state | output | 8 | Receive forced state code |
| tx_force_state | output | 8 | Transmit forced state code |

## Verification
A write takes effect at the clock edge one cycle after the later of its two channel handshakes. That same edge raises bvalid, updates the level outputs and fires a trigger strobe. The bench drives and samples on the falling edge, so it checks that bvalid is still low at the first falling edge after the handshakes and high at the next one. Read data is due at the first falling edge after the address handshake, and the bench checks it there and again one cycle later while rready is held low. Strobes are counted by a falling-edge monitor, which also flags any strobe that lasts two consecutive cycles.

// File: rtl/ofl_regs_pkg.sv
package ofl_regs_pkg;
  localparam int unsigned REG_DW    = 32;
  localparam int unsigned REG_BYTES = REG_DW / 8;
  localparam int unsigned STATE_W   = 8;

  // Byte offsets (software decodes these)
  localparam logic [15:0] OFS_VERSION  = 16'h0000;
  localparam logic [15:0] OFS_SCRATCH  = 16'h0008;
  localparam logic [15:0] OFS_MAGIC    = 16'h000C;
  localparam logic [15:0] OFS_CAPS     = 16'h0010;
  localparam logic [15:0] OFS_PATH_RST = 16'h0084;
  localparam logic [15:0] OFS_RX_CTRL  = 16'h0088;
  localparam logic [15:0] OFS_TX_CTRL  = 16'h008C;
  localparam logic [15:0] OFS_TRIGGER  = 16'h0100;
  localparam logic [15:0] OFS_RX_MODE  = 16'h0104;
  localparam logic [15:0] OFS_TX_MODE  = 16'h0108;
  localparam logic [15:0] OFS_RX_DBG   = 16'h0200;
  localparam logic [15:0] OFS_TX_DBG   = 16'h0204;

  localparam logic [REG_DW-1:0] MAGIC_WORD = 32'h4441_4F46;

  typedef enum logic [1:0] {
    TRIG_AUTO = 2'd0,
    TRIG_HW   = 2'd1,
    TRIG_SW   = 2'd2,
    TRIG_RSVD = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic               rx_rst;
    logic               tx_rst;
    logic               rx_bypass;
    logic               tx_bypass;
    logic               tx_oneshot;
    trig_mode_e         rx_mode;
    trig_mode_e         tx_mode;
    logic [STATE_W-1:0] rx_force;
    logic [STATE_W-1:0] tx_force;
  } ctl_fields_t;
endpackage

// File: rtl/ofl_axil_wr.sv
module ofl_axil_wr #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DW     = 32,
  localparam int unsigned SW    = DW / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              awvalid,
  input  logic [ADDR_W-1:0] awaddr,
  output logic              awready,
  input  logic              wvalid,
  input  logic [DW-1:0]     wdata,
  input  logic [SW-1:0]     wstrb,
  output logic              wready,
  output logic              bvalid,
  output logic [1:0]        bresp,
  input  logic              bready,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic [SW-1:0]     wr_strb
);
  logic              aw_held, w_held, bvalid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic [SW-1:0]     strb_q;

  assign awready = !aw_held && !bvalid_q;
  assign wready  = !w_held && !bvalid_q;
  assign wr_fire = aw_held && w_held;
  assign wr_addr = addr_q;
  assign wr_data = data_q;
  assign wr_strb = strb_q;
  assign bvalid  = bvalid_q;
  assign bresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_held  <= 1'b0;
      w_held   <= 1'b0;
      bvalid_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      strb_q   <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_held <= 1'b1;
        addr_q  <= awaddr;
      end
      if (wvalid && wready) begin
        w_held <= 1'b1;
        data_q <= wdata;
        strb_q <= wstrb;
      end
      if (wr_fire) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  // R4: response is held until the host takes it
  p_bvalid_hold_r4: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid);
  // R4: a response only follows both halves of the write
  p_resp_after_both_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bvalid) |-> $past(aw_held && w_held));
  // R4: a captured address does not move while waiting for data
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    aw_held && !w_held |=> $stable(wr_addr));
endmodule

// File: rtl/ofl_axil_rd.sv
module ofl_axil_rd #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arvalid,
  input  logic [ADDR_W-1:0] araddr,
  output logic              arready,
  output logic              rvalid,
  output logic [1:0]        rresp,
  output logic [DW-1:0]     rdata,
  input  logic              rready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     rd_value
);
  logic          rvalid_q;
  logic [DW-1:0] rdata_q;

  assign arready = !rvalid_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = 2'b00;
  assign rd_addr = araddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid && arready) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_value;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end

  // R5: returned data is stable while the host stalls
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R5: read data follows an accepted address
  p_rvalid_after_ar_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |-> $past(arvalid));
endmodule

// File: rtl/ofl_reg_core.sv
module ofl_reg_core
  import ofl_regs_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned VER_MAJOR    = 1,
  parameter int unsigned VER_MINOR    = 2,
  parameter int unsigned VER_PATCH    = 3,
  parameter bit          HAS_RX       = 1'b1,
  parameter bit          HAS_TX       = 1'b1,
  parameter bit          MEM_EXTERNAL = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_fire,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_DW-1:0]  wr_data,
  input  logic [REG_BYTES-1:0] wr_strb,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_DW-1:0]  rd_value,
  input  logic [STATE_W-1:0] rx_state,
  input  logic [STATE_W-1:0] tx_state,
  input  logic               tx_empty_rd,
  output ctl_fields_t        ctl,
  output logic               rx_trig,
  output logic               tx_trig
);
  localparam logic [REG_DW-1:0] VERSION_WORD =
    {16'(VER_MAJOR), 8'(VER_MINOR), 8'(VER_PATCH)};
  localparam logic [REG_DW-1:0] CAPS_WORD =
    {29'd0, MEM_EXTERNAL, HAS_TX, HAS_RX};

  logic [REG_DW-1:0] scratch_q;
  ctl_fields_t       ctl_q;
  logic              rx_trig_q, tx_trig_q;

  // Per-register write selects
  logic sel_scratch, sel_rst, sel_rxc, sel_txc, sel_trig;
  logic sel_rxm, sel_txm, sel_rxd, sel_txd;
  always_comb begin
    sel_scratch = wr_fire && (wr_addr == ADDR_W'(OFS_SCRATCH));
    sel_rst     = wr_fire && (wr_addr == ADDR_W'(OFS_PATH_RST));
    sel_rxc     = wr_fire && (wr_addr == ADDR_W'(OFS_RX_CTRL));
    sel_txc     = wr_fire && (wr_addr == ADDR_W'(OFS_TX_CTRL));
    sel_trig    = wr_fire && (wr_addr == ADDR_W'(OFS_TRIGGER));
    sel_rxm     = wr_fire && (wr_addr == ADDR_W'(OFS_RX_MODE));
    sel_txm     = wr_fire && (wr_addr == ADDR_W'(OFS_TX_MODE));
    sel_rxd     = wr_fire && (wr_addr == ADDR_W'(OFS_RX_DBG));
    sel_txd     = wr_fire && (wr_addr == ADDR_W'(OFS_TX_DBG));
  end

  // Scratch word: one lane per strobe bit
  for (genvar g = 0; g < REG_BYTES; g++) begin : g_scratch_lane
    always_ff @(posedge clk) begin
      if (rst) scratch_q[8*g +: 8] <= '0;
      else if (sel_scratch && wr_strb[g]) scratch_q[8*g +: 8] <= wr_data[8*g +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      rx_trig_q <= 1'b0;
      tx_trig_q <= 1'b0;
    end else begin
      rx_trig_q <= sel_trig && wr_strb[0] && wr_data[0];
      tx_trig_q <= sel_trig && wr_strb[0] && wr_data[1];
      if (sel_rst && wr_strb[0]) begin
        ctl_q.rx_rst <= wr_data[0];
        ctl_q.tx_rst <= wr_data[1];
      end
      if (sel_rxc && wr_strb[0]) ctl_q.rx_bypass <= wr_data[0];
      if (sel_txc && wr_strb[0]) begin
        ctl_q.tx_bypass  <= wr_data[0];
        ctl_q.tx_oneshot <= wr_data[1];
      end
      if (sel_rxm && wr_strb[0]) ctl_q.rx_mode <= trig_mode_e'(wr_data[1:0]);
      if (sel_txm && wr_strb[0]) ctl_q.tx_mode <= trig_mode_e'(wr_data[1:0]);
      if (sel_rxd && wr_strb[1]) ctl_q.rx_force <= wr_data[15:8];
      if (sel_txd && wr_strb[1]) ctl_q.tx_force <= wr_data[15:8];
    end
  end

  assign ctl     = ctl_q;
  assign rx_trig = rx_trig_q;
  assign tx_trig = tx_trig_q;

  // Read decode, full address compare
  always_comb begin
    rd_value = '0;
    case (rd_addr)
      ADDR_W'(OFS_VERSION):  rd_value = VERSION_WORD;
      ADDR_W'(OFS_SCRATCH):  rd_value = scratch_q;
      ADDR_W'(OFS_MAGIC):    rd_value = MAGIC_WORD;
      ADDR_W'(OFS_CAPS):     rd_value = CAPS_WORD;
      ADDR_W'(OFS_PATH_RST): rd_value = {30'd0, ctl_q.tx_rst, ctl_q.rx_rst};
      ADDR_W'(OFS_RX_CTRL):  rd_value = {31'd0, ctl_q.rx_bypass};
      ADDR_W'(OFS_TX_CTRL):  rd_value = {30'd0, ctl_q.tx_oneshot, ctl_q.tx_bypass};
      ADDR_W'(OFS_TRIGGER):  rd_value = '0;
      ADDR_W'(OFS_RX_MODE):  rd_value = {30'd0, ctl_q.rx_mode};
      ADDR_W'(OFS_TX_MODE):  rd_value = {30'd0, ctl_q.tx_mode};
      ADDR_W'(OFS_RX_DBG):   rd_value = {16'd0, ctl_q.rx_force, rx_state};
      ADDR_W'(OFS_TX_DBG):   rd_value = {15'd0, tx_empty_rd, ctl_q.tx_force, tx_state};
      default:               rd_value = '0;
    endcase
  end

  // R8: trigger strobes last a single cycle
  p_rx_trig_single_r8: assert property (@(posedge clk) disable iff (rst)
    rx_trig |=> !rx_trig);
  p_tx_trig_single_r8: assert property (@(posedge clk) disable iff (rst)
    tx_trig |=> !tx_trig);
  // R10: forced states move only on a completed write
  p_force_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> $stable(ctl.rx_force) && $stable(ctl.tx_force));
  // R11: control fields never change without a write
  p_ctl_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> $stable(ctl));
endmodule

// File: rtl/ofl_ctrl_regs.sv
module ofl_ctrl_regs
  import ofl_regs_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned VER_MAJOR    = 1,
  parameter int unsigned VER_MINOR    = 2,
  parameter int unsigned VER_PATCH    = 3,
  parameter bit          HAS_RX       = 1'b1,
  parameter bit          HAS_TX       = 1'b1,
  parameter bit          MEM_EXTERNAL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 axil_awvalid,
  input  logic [ADDR_W-1:0]    axil_awaddr,
  output logic                 axil_awready,
  input  logic                 axil_wvalid,
  input  logic [REG_DW-1:0]    axil_wdata,
  input  logic [REG_BYTES-1:0] axil_wstrb,
  output logic                 axil_wready,
  output logic                 axil_bvalid,
  output logic [1:0]           axil_bresp,
  input  logic                 axil_bready,
  input  logic                 axil_arvalid,
  input  logic [ADDR_W-1:0]    axil_araddr,
  output logic                 axil_arready,
  output logic                 axil_rvalid,
  output logic [1:0]           axil_rresp,
  output logic [REG_DW-1:0]    axil_rdata,
  input  logic                 axil_rready,
  input  logic [STATE_W-1:0]   rx_cur_state,
  input  logic [STATE_W-1:0]   tx_cur_state,
  input  logic                 tx_empty_read,
  output logic                 rx_path_rst,
  output logic                 tx_path_rst,
  output logic                 rx_bypass,
  output logic                 tx_bypass,
  output logic                 tx_oneshot,
  output logic                 rx_trig,
  output logic                 tx_trig,
  output logic [1:0]           rx_trig_mode,
  output logic [1:0]           tx_trig_mode,
  output logic [STATE_W-1:0]   rx_force_state,
  output logic [STATE_W-1:0]   tx_force_state
);
  logic                 wr_fire;
  logic [ADDR_W-1:0]    wr_addr, rd_addr;
  logic [REG_DW-1:0]    wr_data, rd_value;
  logic [REG_BYTES-1:0] wr_strb;
  ctl_fields_t          ctl;

  ofl_axil_wr #(.ADDR_W(ADDR_W), .DW(REG_DW)) u_wr (
    .clk(clk), .rst(rst),
    .awvalid(axil_awvalid), .awaddr(axil_awaddr), .awready(axil_awready),
    .wvalid(axil_wvalid), .wdata(axil_wdata), .wstrb(axil_wstrb), .wready(axil_wready),
    .bvalid(axil_bvalid), .bresp(axil_bresp), .bready(axil_bready),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  ofl_axil_rd #(.ADDR_W(ADDR_W), .DW(REG_DW)) u_rd (
    .clk(clk), .rst(rst),
    .arvalid(axil_arvalid), .araddr(axil_araddr), .arready(axil_arready),
    .rvalid(axil_rvalid), .rresp(axil_rresp), .rdata(axil_rdata), .rready(axil_rready),
    .rd_addr(rd_addr), .rd_value(rd_value)
  );

  ofl_reg_core #(
    .ADDR_W(ADDR_W), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR),
    .VER_PATCH(VER_PATCH), .HAS_RX(HAS_RX), .HAS_TX(HAS_TX),
    .MEM_EXTERNAL(MEM_EXTERNAL)
  ) u_core (
    .clk(clk), .rst(rst),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_addr(rd_addr), .rd_value(rd_value),
    .rx_state(rx_cur_state), .tx_state(tx_cur_state), .tx_empty_rd(tx_empty_read),
    .ctl(ctl), .rx_trig(rx_trig), .tx_trig(tx_trig)
  );

  assign rx_path_rst    = ctl.rx_rst;
  assign tx_path_rst    = ctl.tx_rst;
  assign rx_bypass      = ctl.rx_bypass;
  assign tx_bypass      = ctl.tx_bypass;
  assign tx_oneshot     = ctl.tx_oneshot;
  assign rx_trig_mode   = ctl.rx_mode;
  assign tx_trig_mode   = ctl.tx_mode;
  assign rx_force_state = ctl.rx_force;
  assign tx_force_state = ctl.tx_force;

  // R8: a strobe appears only together with a write response
  p_trig_with_resp_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_trig || tx_trig) |-> $rose(axil_bvalid));
endmodule

// File: tb/sim_ofl_ctrl_regs.sv
module sim_ofl_ctrl_regs;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        axil_awvalid = 0, axil_wvalid = 0, axil_bready = 0;
  logic        axil_arvalid = 0, axil_rready = 0;
  logic [15:0] axil_awaddr = '0, axil_araddr = '0;
  logic [31:0] axil_wdata = '0;
  logic [3:0]  axil_wstrb = '0;
  logic        axil_awready, axil_wready, axil_bvalid, axil_arready, axil_rvalid;
  logic [1:0]  axil_bresp, axil_rresp;
  logic [31:0] axil_rdata;
  logic [7:0]  rx_cur_state = '0, tx_cur_state = '0;
  logic        tx_empty_read = 0;
  logic        rx_path_rst, tx_path_rst, rx_bypass, tx_bypass, tx_oneshot;
  logic        rx_trig, tx_trig;
  logic [1:0]  rx_trig_mode, tx_trig_mode;
  logic [7:0]  rx_force_state, tx_force_state;

  int checks = 0, fails = 0, cyc = 0;
  int rx_pulses = 0, tx_pulses = 0, wide_pulses = 0;
  logic rx_prev = 0, tx_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofl_ctrl_regs u0 (.*);

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_trig) rx_pulses++;
      if (tx_trig) tx_pulses++;
      if ((rx_trig && rx_prev) || (tx_trig && tx_prev)) wide_pulses++;
    end
    rx_prev = rx_trig;
    tx_prev = tx_trig;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      checks++; fails++;
      $display("FAIL R4 watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic send_aw(input logic [15:0] a);
    logic ok = 0;
    axil_awaddr = a; axil_awvalid = 1;
    while (!ok) begin ok = axil_awready; @(negedge clk); end
    axil_awvalid = 0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    logic ok = 0;
    axil_wdata = d; axil_wstrb = s; axil_wvalid = 1;
    while (!ok) begin ok = axil_wready; @(negedge clk); end
    axil_wvalid = 0;
  endtask

  // order: 0 same cycle, 1 address first, 2 data first
  task automatic axi_write(input logic [15:0] a, input logic [31:0] d,
                           input logic [3:0] s, input int order);
    if (order == 1) begin
      send_aw(a);
      repeat (3) begin chk("R4 no response before data", 32'(axil_bvalid), 0); @(negedge clk); end
      send_w(d, s);
    end else if (order == 2) begin
      send_w(d, s);
      repeat (3) begin chk("R4 no response before address", 32'(axil_bvalid), 0); @(negedge clk); end
      send_aw(a);
    end else begin
      logic a_ok, w_ok;
      axil_awaddr = a; axil_awvalid = 1;
      axil_wdata = d; axil_wstrb = s; axil_wvalid = 1;
      while (axil_awvalid || axil_wvalid) begin
        a_ok = axil_awvalid && axil_awready;
        w_ok = axil_wvalid && axil_wready;
        @(negedge clk);
        if (a_ok) axil_awvalid = 0;
        if (w_ok) axil_wvalid = 0;
      end
    end
    chk("R4 bvalid low right after handshakes", 32'(axil_bvalid), 0);
    @(negedge clk);
    chk("R4 bvalid one cycle after handshakes", 32'(axil_bvalid), 1);
    chk("R4 bresp OKAY", 32'(axil_bresp), 0);
    @(negedge clk);
    chk("R4 bvalid held without bready", 32'(axil_bvalid), 1);
    axil_bready = 1;
    @(negedge clk);
    axil_bready = 0;
    chk("R4 bvalid drops after bready", 32'(axil_bvalid), 0);
  endtask

  task automatic axi_read(input logic [15:0] a, output logic [31:0] d);
    logic ok = 0;
    logic [31:0] first;
    axil_araddr = a; axil_arvalid = 1;
    while (!ok) begin ok = axil_arready; @(negedge clk); end
    axil_arvalid = 0;
    chk("R5 rvalid one cycle after address", 32'(axil_rvalid), 1);
    chk("R5 rresp OKAY", 32'(axil_rresp), 0);
    first = axil_rdata;
    @(negedge clk);
    chk("R5 rdata held without rready", axil_rdata, first);
    axil_rready = 1;
    @(negedge clk);
    axil_rready = 0;
    chk("R5 rvalid drops after rready", 32'(axil_rvalid), 0);
    d = first;
  endtask

  task automatic t_reset();
    chk("R1 path resets", {rx_path_rst, tx_path_rst}, 0);
    chk("R1 bypass and oneshot", {rx_bypass, tx_bypass, tx_oneshot}, 0);
    chk("R1 trigger strobes", {rx_trig, tx_trig}, 0);
    chk("R1 trigger modes auto", {rx_trig_mode, tx_trig_mode}, 0);
    chk("R1 forced states", {rx_force_state, tx_force_state}, 0);
    chk("R1 bvalid rvalid low", {axil_bvalid, axil_rvalid}, 0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    axi_read(16'h0000, d); chk("R2 version word", d, 32'h0001_0203);
    axi_read(16'h000C, d); chk("R2 magic word", d, 32'h4441_4F46);
    axi_read(16'h0010, d); chk("R2 capability bits", d, 32'h0000_0003);
  endtask

  task automatic t_scratch();
    logic [31:0] d;
    axi_write(16'h0008, 32'h1122_3344, 4'hF, 0);
    axi_read(16'h0008, d); chk("R3 scratch full write", d, 32'h1122_3344);
    axi_write(16'h0008, 32'hAABB_CCDD, 4'b0101, 0);
    axi_read(16'h0008, d); chk("R3 scratch byte strobes", d, 32'h11BB_33DD);
  endtask

  task automatic t_order();
    logic [31:0] d;
    axi_write(16'h0008, 32'hCAFE_0001, 4'hF, 1);
    axi_read(16'h0008, d); chk("R4 address-first write", d, 32'hCAFE_0001);
    axi_write(16'h0008, 32'hCAFE_0002, 4'hF, 2);
    axi_read(16'h0008, d); chk("R4 data-first write", d, 32'hCAFE_0002);
  endtask

  task automatic t_unmapped_read();
    logic [31:0] d;
    axi_read(16'h0300, d); chk("R5 unmapped reads zero", d, 0);
    axi_read(16'h0009, d); chk("R5 unaligned reads zero", d, 0);
  endtask

  task automatic t_path_rst();
    logic [31:0] d;
    axi_write(16'h0084, 32'h2, 4'hF, 0);
    chk("R6 tx_path_rst set", {rx_path_rst, tx_path_rst}, 2'b01);
    axi_read(16'h0084, d); chk("R6 reset word readback", d, 2);
    axi_write(16'h0084, 32'h1, 4'hF, 0);
    chk("R6 rx_path_rst set", {rx_path_rst, tx_path_rst}, 2'b10);
    axi_write(16'h0084, 32'h0, 4'hF, 0);
    chk("R6 resets cleared", {rx_path_rst, tx_path_rst}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    axi_write(16'h0088, 32'hFFFF_FFFF, 4'hF, 0);
    chk("R7 rx_bypass", 32'(rx_bypass), 1);
    axi_read(16'h0088, d); chk("R7 rx control readback", d, 1);
    axi_write(16'h008C, 32'h2, 4'hF, 0);
    chk("R7 oneshot without bypass", {tx_bypass, tx_oneshot}, 2'b01);
    axi_write(16'h008C, 32'hFFFF_FFFF, 4'hF, 0);
    chk("R7 tx bypass and oneshot", {tx_bypass, tx_oneshot}, 2'b11);
    axi_read(16'h008C, d); chk("R7 tx control readback", d, 3);
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    int rx0, tx0;
    rx0 = rx_pulses; tx0 = tx_pulses;
    axi_write(16'h0100, 32'h1, 4'hF, 0);
    chk("R8 rx strobe count", rx_pulses - rx0, 1);
    chk("R8 no tx strobe", tx_pulses - tx0, 0);
    axi_write(16'h0100, 32'h3, 4'hF, 1);
    chk("R8 both strobes rx", rx_pulses - rx0, 2);
    chk("R8 both strobes tx", tx_pulses - tx0, 1);
    axi_write(16'h0100, 32'h0, 4'hF, 0);
    axi_write(16'h0100, 32'h3, 4'h0, 0);
    chk("R8 zero or masked write gives no strobe", (rx_pulses - rx0) + (tx_pulses - tx0), 3);
    axi_read(16'h0100, d); chk("R8 trigger word reads zero", d, 0);
    chk("R8 strobes one cycle wide", wide_pulses, 0);
  endtask

  task automatic t_modes();
    logic [31:0] d;
    axi_write(16'h0104, 32'hFFFF_FFFE, 4'hF, 0);
    chk("R9 rx mode software", 32'(rx_trig_mode), 2);
    axi_read(16'h0104, d); chk("R9 rx mode readback", d, 2);
    axi_write(16'h0108, 32'h1, 4'hF, 2);
    chk("R9 tx mode hardware", 32'(tx_trig_mode), 1);
    axi_read(16'h0108, d); chk("R9 tx mode readback", d, 1);
  endtask

  task automatic t_debug();
    logic [31:0] d;
    rx_cur_state = 8'h5A;
    axi_write(16'h0200, 32'h0000_3CFF, 4'b0011, 0);
    chk("R10 rx force output", 32'(rx_force_state), 32'h3C);
    axi_read(16'h0200, d); chk("R10 rx debug word", d, 32'h0000_3C5A);
    axi_write(16'h0200, 32'h0000_7700, 4'b0001, 0);
    chk("R10 force needs byte 1 strobe", 32'(rx_force_state), 32'h3C);
    tx_cur_state = 8'hA5; tx_empty_read = 1;
    axi_write(16'h0204, 32'h0001_9900, 4'hF, 0);
    chk("R10 tx force output", 32'(tx_force_state), 32'h99);
    axi_read(16'h0204, d); chk("R10 tx debug with flag", d, 32'h0001_99A5);
    tx_empty_read = 0;
    axi_read(16'h0204, d); chk("R10 tx debug flag follows input", d, 32'h0000_99A5);
  endtask

  task automatic t_ro_ignore();
    logic [31:0] d;
    axi_write(16'h000C, 32'h0, 4'hF, 0);
    axi_write(16'h0010, 32'hFF, 4'hF, 0);
    axi_write(16'h0000, 32'h0, 4'hF, 0);
    axi_write(16'h0300, 32'hFFFF_FFFF, 4'hF, 0);
    axi_read(16'h000C, d); chk("R11 magic unchanged", d, 32'h4441_4F46);
    axi_read(16'h0010, d); chk("R11 caps unchanged", d, 3);
    axi_read(16'h0000, d); chk("R11 version unchanged", d, 32'h0001_0203);
    axi_read(16'h0008, d); chk("R11 scratch untouched", d, 32'hCAFE_0002);
    axi_read(16'h0300, d); chk("R11 unmapped still zero", d, 0);
    chk("R11 controls untouched", {rx_path_rst, tx_path_rst, rx_bypass, tx_bypass, tx_oneshot}, 5'b00111);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_ident();
    t_scratch();
    t_order();
    t_unmapped_read();
    t_path_rst();
    t_ctrl();
    t_trigger();
    t_modes();
    t_debug();
    t_ro_ignore();
    summary();
    $finish;
  end
endmodule